// File: doc/BRIEF.md
# NAND 1-bit ECC Sector Fixer

This block closes the loop on single-error correction for a 512-byte NAND sector protected by a 24-bit Hamming code split into two 12-bit halves. It receives two things for each sector. The first is the three code bytes read back from the spare area, packed with byte 0 in the low eight bits. The second is the 32-bit parity word that the column/row parity engine produced while the sector streamed past. The block folds that word into the stored-code convention and compares the two codes. It then classifies the sector as clean, corrected, or uncorrectable.

When the difference points at a single flipped data bit inside the sector, the block repairs the sector buffer itself. It reads the damaged byte on a simple synchronous buffer port, then writes it back with the bad bit inverted. When the difference is a single bit, the error sits in the stored code bytes and needs no data change. Every accepted job ends with a one-cycle `done` pulse that carries the status and, for data repairs, the byte offset and bit index.

Top module: `ecc1b_sector_fixer`

## Requirements
- R1: The stored code is taken as `stored_code[23:0]`, with byte 0 in bits [7:0]. The recomputed code is the bitwise inverse of {`raw_parity[27:16]`, `raw_parity[11:0]`}, so bits [31:28] and [15:12] of the parity word have no effect. An erased sector (stored 0xFFFFFF, parity 0) compares clean.
- R2: When the XOR difference of the two codes is zero, the block reports status 0 (clean) with `done` one cycle after `start` is sampled, and the buffer port is not used.
- R3: When diff[11:0] XOR diff[23:12] equals 0xFFF and diff[23:15] is below SECTOR_BYTES, the block reports status 1. It reports `err_byte` = diff[23:15] and `err_bit` = diff[14:12].
- R4: For an R3 case, the buffer port asserts `buf_rd_en` at address `err_byte` in the cycle after acceptance. Read data returns one cycle after the read. In the next cycle the port asserts `buf_wr_en` at the same address, with the data set to the read byte XOR (1 << `err_bit`). `done` follows in the cycle after the write.
- R5: An R3-pattern difference whose byte offset is not below SECTOR_BYTES reports status 2, with `done` after one cycle and no buffer access.
- R6: A difference with exactly one bit set reports status 1, with `err_byte` and `err_bit` at zero and no buffer access.
- R7: Any other nonzero difference reports status 2 with no buffer access.
- R8: The status encoding is 0 = clean, 1 = corrected, 2 = uncorrectable. `done` pulses for exactly one cycle per accepted job. `status`, `err_byte` and `err_bit` read zero whenever `done` is low.
- R9: A `start` that arrives while a buffer repair is in its read or write cycle is ignored. It produces no result and no extra buffer access.
- R10: A `start` in the cycle that `done` is high is accepted. Jobs that need no repair can be issued every cycle, and each produces its own `done` one cycle later, in order.
- R11: While `rst_n` is low at a clock edge, `done`, `buf_rd_en` and `buf_wr_en` clear and `status` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept a job when idle |
| stored_code | input | 24 | Code bytes from flash, byte 0 in [7:0] |
| raw_parity | input | 32 | Parity word from the sector parity engine |
| done | output | 1 | One-cycle result strobe |
| status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| err_byte | output | 9 | Byte offset of a repaired data bit |
| err_bit | output | 3 | Bit index of a repaired data bit |
| buf_addr | output | ADDR_W | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_data | input | 8 | Buffer read data, one cycle after the request |
| buf_wr_en | output | 1 | Buffer write request |
| buf_wr_data | output | 8 | Repaired byte |

## Verification
Two things can land in the same cycle. One is the completion of one job, when `done` reports its result. The other is the acceptance of the next `start`, either for a job that needs no repair or for a repair whose read must then begin. The bench provokes this in two ways. It streams clean, ECC-only and uncorrectable jobs with `start` held high on consecutive cycles, and it launches a new job exactly in the `done` cycle of a data repair. A scoreboard judges the result: each `done` must pop the matching expected item in order, with the right status, location, running write count and repaired buffer byte. A separate case holds `start` through a repair's read and write cycles and expects no extra result.

// File: rtl/ecc1b_pkg.sv
// Shared types for the 1-bit ECC sector fixer.
// Assumes a 24-bit code built from two 12-bit parity halves.
package ecc1b_pkg;

    localparam int CODE_W = 24;                   // full code width
    localparam int HALF_W = CODE_W / 2;           // one parity half
    localparam int BIT_W  = 3;                    // bit index within a byte
    localparam int OFS_W  = HALF_W - BIT_W;       // byte offset width
    localparam int BYTE_W = 8;                    // buffer data width
    localparam int RAW_W  = 32;                   // parity word width
    localparam int RAW_HI = 16;                   // start of upper half in parity word

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_BAD   = 2'd2
    } fix_status_e;

    typedef struct packed {
        fix_status_e            status;
        logic                   needs_write;
        logic [OFS_W-1:0]       byte_ofs;
        logic [BIT_W-1:0]       bit_idx;
    } verdict_t;

endpackage

// File: rtl/ecc1b_code_pack.sv
// Folds the raw 32-bit parity word into the stored-code convention.
// The two 12-bit halves are taken from [11:0] and [27:16] and inverted,
// so an all-0xFF erased sector yields a matching code.
module ecc1b_code_pack
    import ecc1b_pkg::*;
(
    input  logic [RAW_W-1:0]  raw_parity,
    output logic [CODE_W-1:0] code
);

    logic unused_raw_bits;

    // Pack the two halves and invert them.
    always_comb begin
        code = ~{raw_parity[RAW_HI +: HALF_W], raw_parity[0 +: HALF_W]};
    end

    // Bits between and above the halves carry nothing.
    assign unused_raw_bits = ^{raw_parity[RAW_W-1:RAW_HI+HALF_W],
                               raw_parity[RAW_HI-1:HALF_W]};

endmodule

// File: rtl/ecc1b_classify.sv
// Compares stored and recomputed codes and returns a verdict.
// Purely combinational; assumes a sector of SECTOR_BYTES bytes.
module ecc1b_classify
    import ecc1b_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] stored,
    input  logic [CODE_W-1:0] computed,
    output verdict_t          verdict
);

    logic [CODE_W-1:0] diff;
    logic [HALF_W-1:0] fold;
    logic [OFS_W-1:0]  ofs;
    logic [BIT_W-1:0]  bidx;
    logic              single_bit;
    logic              in_range;

    // Difference and its derived fields.
    always_comb begin
        diff       = stored ^ computed;
        fold       = diff[HALF_W-1:0] ^ diff[CODE_W-1:HALF_W];
        ofs        = diff[CODE_W-1 -: OFS_W];
        bidx       = diff[HALF_W +: BIT_W];
        single_bit = ((diff & (diff - 1'b1)) == '0);
        in_range   = (32'(ofs) < SECTOR_BYTES);
    end

    // Decide the verdict in priority order.
    always_comb begin
        verdict        = '0;
        verdict.status = ST_CLEAN;
        if (diff == '0) begin
            verdict.status = ST_CLEAN;
        end else if (fold == '1) begin
            if (in_range) begin
                verdict.status      = ST_FIXED;
                verdict.needs_write = 1'b1;
                verdict.byte_ofs    = ofs;
                verdict.bit_idx     = bidx;
            end else begin
                verdict.status = ST_BAD;
            end
        end else if (single_bit) begin
            verdict.status = ST_FIXED;
        end else begin
            verdict.status = ST_BAD;
        end
    end

endmodule

// File: rtl/ecc1b_fix_sequencer.sv
// Accepts a verdict on start, runs the read-modify-write repair on the
// buffer port when one is needed, and emits a one-cycle done with the result.
// Assumes buffer read data arrives one cycle after buf_rd_en.
module ecc1b_fix_sequencer
    import ecc1b_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  verdict_t          verdict,
    output logic              done,
    output logic [1:0]        status,
    output logic [OFS_W-1:0]  err_byte,
    output logic [BIT_W-1:0]  err_bit,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd_en,
    input  logic [BYTE_W-1:0] buf_rd_data,
    output logic              buf_wr_en,
    output logic [BYTE_W-1:0] buf_wr_data
);

    typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_e;

    phase_e            phase_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [BIT_W-1:0]  bit_q;
    logic              done_q;
    fix_status_e       status_q;
    logic [OFS_W-1:0]  rep_byte_q;
    logic [BIT_W-1:0]  rep_bit_q;

    // Phase control, repair target capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            ofs_q      <= '0;
            bit_q      <= '0;
            done_q     <= 1'b0;
            status_q   <= ST_CLEAN;
            rep_byte_q <= '0;
            rep_bit_q  <= '0;
        end else begin
            done_q     <= 1'b0;
            status_q   <= ST_CLEAN;
            rep_byte_q <= '0;
            rep_bit_q  <= '0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        if (verdict.needs_write) begin
                            ofs_q   <= verdict.byte_ofs;
                            bit_q   <= verdict.bit_idx;
                            phase_q <= PH_READ;
                        end else begin
                            done_q     <= 1'b1;
                            status_q   <= verdict.status;
                            rep_byte_q <= verdict.byte_ofs;
                            rep_bit_q  <= verdict.bit_idx;
                        end
                    end
                end
                PH_READ: begin
                    phase_q <= PH_WRITE;
                end
                PH_WRITE: begin
                    phase_q    <= PH_IDLE;
                    done_q     <= 1'b1;
                    status_q   <= ST_FIXED;
                    rep_byte_q <= ofs_q;
                    rep_bit_q  <= bit_q;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Buffer port driven from the phase and the captured target.
    always_comb begin
        buf_rd_en   = (phase_q == PH_READ);
        buf_wr_en   = (phase_q == PH_WRITE);
        buf_addr    = ADDR_W'(ofs_q);
        buf_wr_data = buf_rd_data ^ (BYTE_W'(1) << bit_q);
    end

    // Result outputs.
    always_comb begin
        done     = done_q;
        status   = status_q;
        err_byte = rep_byte_q;
        err_bit  = rep_bit_q;
    end

endmodule

// File: rtl/ecc1b_sector_fixer.sv
// Top of the 1-bit ECC sector fixer: packs the recomputed parity, classifies
// the code difference and repairs a single data bit in the sector buffer.
// Assumes a synchronous buffer with one-cycle read latency.
module ecc1b_sector_fixer
    import ecc1b_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [23:0]       stored_code,
    input  logic [31:0]       raw_parity,
    output logic              done,
    output logic [1:0]        status,
    output logic [8:0]        err_byte,
    output logic [2:0]        err_bit,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd_en,
    input  logic [7:0]        buf_rd_data,
    output logic              buf_wr_en,
    output logic [7:0]        buf_wr_data
);

    logic [CODE_W-1:0] computed_code;
    verdict_t          verdict;

    ecc1b_code_pack u_pack (
        .raw_parity (raw_parity),
        .code       (computed_code)
    );

    ecc1b_classify #(
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_classify (
        .stored   (stored_code),
        .computed (computed_code),
        .verdict  (verdict)
    );

    ecc1b_fix_sequencer #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .verdict     (verdict),
        .done        (done),
        .status      (status),
        .err_byte    (err_byte),
        .err_bit     (err_bit),
        .buf_addr    (buf_addr),
        .buf_rd_en   (buf_rd_en),
        .buf_rd_data (buf_rd_data),
        .buf_wr_en   (buf_wr_en),
        .buf_wr_data (buf_wr_data)
    );

endmodule

// File: rtl/ecc1b_fix_checker.sv
// Protocol checks on the fixer's ports, bound to the top module.
module ecc1b_fix_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [1:0]        status,
    input logic [8:0]        err_byte,
    input logic [2:0]        err_bit,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              buf_rd_en,
    input logic [7:0]        buf_rd_data,
    input logic              buf_wr_en,
    input logic [7:0]        buf_wr_data
);

    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> buf_wr_en);

    a_r4_read_precedes_write: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(buf_rd_en));

    a_r4_same_address: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> buf_addr == $past(buf_addr));

    a_r4_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $countones(buf_wr_data ^ buf_rd_data) == 1);

    a_r4_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |=> (done && status == 2'd1));

    a_r8_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status != 2'd3);

    a_r8_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (status == 2'd0 && err_byte == '0 && err_bit == '0));

    a_r9_no_back_to_back_read: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> !buf_rd_en);

    a_r2_quick_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(buf_wr_en)) |-> $past(start));

    a_r11_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));

endmodule

bind ecc1b_sector_fixer ecc1b_fix_checker #(.ADDR_W(ADDR_W)) u_fix_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .done        (done),
    .status      (status),
    .err_byte    (err_byte),
    .err_bit     (err_bit),
    .buf_addr    (buf_addr),
    .buf_rd_en   (buf_rd_en),
    .buf_rd_data (buf_rd_data),
    .buf_wr_en   (buf_wr_en),
    .buf_wr_data (buf_wr_data)
);

// File: tb/ecc1b_sector_fixer_test.sv
// Scoreboard bench for the 1-bit ECC sector fixer.
module ecc1b_sector_fixer_test;

    localparam int SECTOR = 384;
    localparam int AW     = $clog2(SECTOR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [23:0]   stored_code = '0;
    logic [31:0]   raw_parity = '0;
    logic          done;
    logic [1:0]    status;
    logic [8:0]    err_byte;
    logic [2:0]    err_bit;
    logic [AW-1:0] buf_addr;
    logic          buf_rd_en;
    logic [7:0]    buf_rd_data = '0;
    logic          buf_wr_en;
    logic [7:0]    buf_wr_data;

    always #4 clk = ~clk;

    ecc1b_sector_fixer #(.SECTOR_BYTES(SECTOR)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stored_code(stored_code), .raw_parity(raw_parity),
        .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rd_data(buf_rd_data),
        .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data)
    );

    typedef struct {
        logic [1:0] st;
        logic [8:0] eb;
        logic [2:0] ebit;
        bit         ew;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] mem    [0:511];
    logic [7:0] shadow [0:511];
    int         checks = 0;
    int         errors = 0;
    int         wr_count = 0;
    int         exp_writes = 0;
    int         jobs_pushed = 0;
    int         dones_seen = 0;
    bit         finished = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Buffer model: one-cycle read latency, counts writes.
    always @(posedge clk) begin
        if (buf_rd_en) buf_rd_data <= mem[buf_addr];
        if (buf_wr_en) begin
            mem[buf_addr] <= buf_wr_data;
            wr_count <= wr_count + 1;
        end
    end

    function automatic logic [23:0] calc_of(input logic [31:0] raw);
        return ~{raw[27:16], raw[11:0]};
    endfunction

    function automatic logic [23:0] data_diff(input int b, input int k);
        logic [11:0] hi;
        hi = {9'(b), 3'(k)};
        return {hi, ~hi};
    endfunction

    // Driver: push the expectation, present the job, hold start for one edge.
    task automatic job(input logic [31:0] raw, input logic [23:0] stored,
                       input logic [1:0] est, input int eb, input int ebit,
                       input bit ew, input string tag, input int gap);
        exp_t e;
        e.st = est; e.eb = 9'(eb); e.ebit = 3'(ebit); e.ew = ew; e.tag = tag;
        sb_q.push_back(e);
        jobs_pushed++;
        if (ew) shadow[eb] = shadow[eb] ^ (8'd1 << ebit);
        raw_parity  = raw;
        stored_code = stored;
        start       = 1'b1;
        @(negedge clk);
        if (gap > 0) begin
            start = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    // Monitor: pop and compare at every done.
    always @(negedge clk) begin
        if (rst_n && done) begin
            dones_seen++;
            if (sb_q.size() == 0) begin
                check("R9", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.ew) exp_writes++;
                check(e.tag, "status", int'(status), int'(e.st));
                check(e.tag, "err_byte", int'(err_byte), int'(e.eb));
                check(e.tag, "err_bit", int'(err_bit), int'(e.ebit));
                check(e.tag, "write count", wr_count, exp_writes);
                if (e.ew) check(e.tag, "repaired byte", int'(mem[e.eb]), int'(shadow[e.eb]));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R9 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 512; i++) begin
            mem[i]    = 8'(i * 37 + 11);
            shadow[i] = 8'(i * 37 + 11);
        end
        repeat (5) @(negedge clk);
        // R11: reset state
        check("R11", "done", int'(done), 0);
        check("R11", "rd_en", int'(buf_rd_en), 0);
        check("R11", "wr_en", int'(buf_wr_en), 0);
        check("R11", "status", int'(status), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 erased sector and ignored parity bits; R2 clean
        job(32'h0, 24'hFFFFFF, 2'd0, 0, 0, 0, "R1", 2);
        r = 32'h1234_5678;
        job(32'hF234_F678, calc_of(r), 2'd0, 0, 0, 0, "R1", 2);
        r = 32'h0ABC_0DEF;
        job(r, calc_of(r), 2'd0, 0, 0, 0, "R2", 2);

        // R3/R4 data repairs at boundaries and inside
        r = 32'h0555_0AAA;
        job(r, calc_of(r) ^ data_diff(0, 0), 2'd1, 0, 0, 1, "R3", 4);
        job(r, calc_of(r) ^ data_diff(SECTOR - 1, 7), 2'd1, SECTOR - 1, 7, 1, "R4", 4);
        job(r, calc_of(r) ^ data_diff(100, 5), 2'd1, 100, 5, 1, "R4", 4);

        // R5 offset beyond the sector
        job(r, calc_of(r) ^ data_diff(SECTOR, 2), 2'd2, 0, 0, 0, "R5", 2);
        job(r, calc_of(r) ^ data_diff(511, 7), 2'd2, 0, 0, 0, "R5", 2);

        // R6 single-bit code error, R7 other patterns
        job(r, calc_of(r) ^ 24'h000001, 2'd1, 0, 0, 0, "R6", 2);
        job(r, calc_of(r) ^ 24'h800000, 2'd1, 0, 0, 0, "R6", 2);
        job(r, calc_of(r) ^ 24'h000003, 2'd2, 0, 0, 0, "R7", 2);
        job(r, calc_of(r) ^ 24'h00F00F, 2'd2, 0, 0, 0, "R7", 2);

        // R10 back-to-back jobs without repair, start held high
        job(r, calc_of(r), 2'd0, 0, 0, 0, "R10", 0);
        job(r, calc_of(r) ^ 24'h000400, 2'd1, 0, 0, 0, "R10", 0);
        job(r, calc_of(r) ^ 24'h0F0F00, 2'd2, 0, 0, 0, "R10", 0);
        job(r, calc_of(r), 2'd0, 0, 0, 0, "R10", 2);

        // R9 start held through repair read and write cycles
        job(r, calc_of(r) ^ data_diff(200, 3), 2'd1, 200, 3, 1, "R9", 0);
        raw_parity  = r;
        stored_code = calc_of(r);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);

        // R10 new job accepted in the done cycle of a repair
        job(r, calc_of(r) ^ data_diff(42, 6), 2'd1, 42, 6, 1, "R10", 2);
        job(r, calc_of(r) ^ data_diff(43, 1), 2'd1, 43, 1, 1, "R10", 2);
        job(r, calc_of(r) ^ 24'h000010, 2'd1, 0, 0, 0, "R10", 4);

        repeat (6) @(negedge clk);
        check("R9", "pending items", sb_q.size(), 0);
        check("R9", "done count", dones_seen, jobs_pushed);
        check("R4", "total writes", wr_count, 6);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule